// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block runs register accesses over the narrow control port of a serial PHY. The PHY exposes a 16-bit data input bus, four capture/transfer strobes (address capture, data capture, write, read), one acknowledge line and a 16-bit data output bus. Each strobe uses a four-phase handshake. The master raises the strobe and waits for the acknowledge to rise. It then drops the strobe and waits for the acknowledge to fall.

A controller issues one command at a time: an address capture, a data capture followed by a write, or a read. Each command carries a 16-bit operand and is launched with a start strobe. `busy` stays high for the whole operation. `done` pulses for one cycle at the end, and `err` reports whether an acknowledge wait ran out of polls. The acknowledge is polled once every `POLL_GAP` cycles, and a wait gives up after `MAX_POLLS` polls.

A write whose data has bit 0 set is a PHY self-reset. The PHY cannot answer it, so the master raises the write strobe and finishes at once. A sticky power-down test request is passed to the PHY on a line of its own, and strobe activity never affects it.

Top module: `phyctl_hs_master`

## Requirements
- R1: After reset, all four strobes, `busy`, `done`, `err`, `phy_data_in` and `rd_data` are 0.
- R2: Op code 0 (address capture) places the operand on `phy_data_in`. It then performs one full handshake on `phy_cap_addr` and ends with `done` and `err`=0.
- R3: Op code 1 (write) places the operand on `phy_data_in`. It performs a full handshake on `phy_cap_data`, then a full handshake on `phy_write`, and no other strobe is used.
- R4: For an op-code-1 write whose operand has bit 0 set, `done` is high in the same cycle that `phy_write` first reads high, with no wait for the acknowledge. `phy_write` stays high until the next accepted command.
- R5: Op code 2 (read) performs a full handshake on `phy_read`. `rd_data` takes `phy_data_out` as sampled while `phy_read` is high and the acknowledge is seen high. `phy_data_in` keeps its previous value.
- R6: A wait for the acknowledge level that is still unmet after `MAX_POLLS` polls, spaced `POLL_GAP` cycles apart, ends the command. It raises `err` together with `done` and runs none of the remaining phases. A timeout on the rising acknowledge gives `done` exactly 1+(MAX_POLLS-1)*POLL_GAP cycles after the strobe rises, with the strobe still high. `err` returns to 0 when the next command is accepted.
- R7: A start while `busy` is high, or a start with op code 3, is ignored. The strobes, `phy_data_in` and `busy` are unaffected.
- R8: `done` is high for exactly one cycle per command.
- R9: `phy_pd_test` follows `pd_test_req` one cycle later, whatever the strobes are doing.
- R10: At most one strobe is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start strobe for one command |
| cmd_op | input | 2 | 0 address capture, 1 write, 2 read, 3 ignored |
| cmd_operand | input | DW | Address or write data |
| pd_test_req | input | 1 | Sticky power-down test request |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Last command timed out |
| rd_data | output | DW | Data captured by the last read |
| phy_data_in | output | DW | Data/address bus to the PHY |
| phy_cap_addr | output | 1 | Address capture strobe |
| phy_cap_data | output | 1 | Data capture strobe |
| phy_write | output | 1 | Write strobe |
| phy_read | output | 1 | Read strobe |
| phy_pd_test | output | 1 | Power-down test line |
| phy_ack | input | 1 | PHY acknowledge |
| phy_data_out | input | DW | PHY read data |

## Verification
The assertions assume that reset is held long enough to clear the registers. They also assume that `pd_test_req` and the command inputs are synchronous to `clk`. They do not assume that the PHY acknowledge is well-behaved: the master must keep its strobe ordering and its one-cycle `done` even when the acknowledge never rises or never falls. The stimulus comes from a bench PHY model that acknowledges after a fixed delay, never acknowledges, or holds the acknowledge high. The model withholds the acknowledge for a write that carries the reset bit. Commands change only at falling clock edges.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;

    localparam int PHY_RESET_BIT = 0;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RSVD  = 2'd3
    } phy_op_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_DATA,
        PH_WR,
        PH_RD
    } phase_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RAISE,
        S_WAIT_HI,
        S_WAIT_LO
    } seq_state_e;

    // Strobe group in PHY control-word order (bits 19..16 above the data field)
    typedef struct packed {
        logic rd;
        logic wr;
        logic cap_data;
        logic cap_addr;
    } strobe_t;

    function automatic strobe_t phase_strobe(input phase_e p);
        strobe_t s;
        s = '0;
        case (p)
            PH_ADDR: s.cap_addr = 1'b1;
            PH_DATA: s.cap_data = 1'b1;
            PH_WR:   s.wr       = 1'b1;
            default: s.rd       = 1'b1;
        endcase
        return s;
    endfunction

    function automatic phase_e first_phase(input phy_op_e op);
        case (op)
            OP_WRITE: return PH_DATA;
            OP_READ:  return PH_RD;
            default:  return PH_ADDR;
        endcase
    endfunction

endpackage

// File: rtl/phyctl_poll_timer.sv
module phyctl_poll_timer #(
    parameter int POLL_GAP  = 100,
    parameter int MAX_POLLS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic miss,
    output logic poll_now,
    output logic last_poll
);
    localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
    localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [GW-1:0] GAP_RELOAD = GW'(POLL_GAP - 1);
    localparam logic [PW-1:0] LAST_IDX   = PW'(MAX_POLLS - 1);

    logic [GW-1:0] gap_q;
    logic [PW-1:0] polls_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            gap_q   <= '0;
            polls_q <= '0;
        end else if (miss) begin
            gap_q   <= GAP_RELOAD;
            polls_q <= polls_q + 1'b1;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign poll_now  = (gap_q == '0);
    assign last_poll = (polls_q == LAST_IDX);
endmodule

// File: rtl/phyctl_seq.sv
module phyctl_seq
    import phyctl_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  phy_op_e       op,
    input  logic [DW-1:0] operand,
    input  logic          ack,
    input  logic [DW-1:0] phy_dout,
    input  logic          poll_now,
    input  logic          last_poll,
    output logic          tmr_clear,
    output logic          tmr_miss,
    output strobe_t       stb,
    output logic [DW-1:0] din,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rd_data
);
    seq_state_e state;
    phase_e     phase;
    logic       waiting;
    logic       hit;

    assign waiting   = (state == S_WAIT_HI) || (state == S_WAIT_LO);
    assign hit       = (state == S_WAIT_HI) ? ack : !ack;
    assign tmr_clear = (state == S_RAISE) || (waiting && poll_now && hit);
    assign tmr_miss  = waiting && poll_now && !hit && !last_poll;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            phase   <= PH_ADDR;
            stb     <= '0;
            din     <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start && op != OP_RSVD) begin
                        stb <= '0;
                        if (op != OP_READ) din <= operand;
                        phase <= first_phase(op);
                        busy  <= 1'b1;
                        err   <= 1'b0;
                        state <= S_RAISE;
                    end
                end
                S_RAISE: begin
                    stb <= phase_strobe(phase);
                    if (phase == PH_WR && din[PHY_RESET_BIT]) begin
                        // PHY is resetting itself: no acknowledge will come
                        done  <= 1'b1;
                        busy  <= 1'b0;
                        state <= S_IDLE;
                    end else begin
                        state <= S_WAIT_HI;
                    end
                end
                S_WAIT_HI, S_WAIT_LO: begin
                    if (poll_now) begin
                        if (hit) begin
                            if (state == S_WAIT_HI) begin
                                if (phase == PH_RD) rd_data <= phy_dout;
                                stb   <= '0;
                                state <= S_WAIT_LO;
                            end else if (phase == PH_DATA) begin
                                phase <= PH_WR;
                                state <= S_RAISE;
                            end else begin
                                done  <= 1'b1;
                                busy  <= 1'b0;
                                state <= S_IDLE;
                            end
                        end else if (last_poll) begin
                            err   <= 1'b1;
                            done  <= 1'b1;
                            busy  <= 1'b0;
                            state <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phyctl_hs_master.sv
module phyctl_hs_master
    import phyctl_pkg::*;
#(
    parameter int DW        = 16,
    parameter int POLL_GAP  = 100,
    parameter int MAX_POLLS = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_start,
    input  logic [1:0]    cmd_op,
    input  logic [DW-1:0] cmd_operand,
    input  logic          pd_test_req,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] phy_data_in,
    output logic          phy_cap_addr,
    output logic          phy_cap_data,
    output logic          phy_write,
    output logic          phy_read,
    output logic          phy_pd_test,
    input  logic          phy_ack,
    input  logic [DW-1:0] phy_data_out
);
    logic    poll_now, last_poll, tmr_clear, tmr_miss;
    strobe_t stb;
    logic    pd_q;

    phyctl_poll_timer #(
        .POLL_GAP  (POLL_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clear     (tmr_clear),
        .miss      (tmr_miss),
        .poll_now  (poll_now),
        .last_poll (last_poll)
    );

    phyctl_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_start),
        .op        (phy_op_e'(cmd_op)),
        .operand   (cmd_operand),
        .ack       (phy_ack),
        .phy_dout  (phy_data_out),
        .poll_now  (poll_now),
        .last_poll (last_poll),
        .tmr_clear (tmr_clear),
        .tmr_miss  (tmr_miss),
        .stb       (stb),
        .din       (phy_data_in),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rd_data   (rd_data)
    );

    // Power-down test line is held apart from the strobe group
    always_ff @(posedge clk) begin
        if (rst) pd_q <= 1'b0;
        else     pd_q <= pd_test_req;
    end

    assign phy_pd_test  = pd_q;
    assign phy_cap_addr = stb.cap_addr;
    assign phy_cap_data = stb.cap_data;
    assign phy_write    = stb.wr;
    assign phy_read     = stb.rd;
endmodule

// File: rtl/phyctl_hs_master_chk.sv
module phyctl_hs_master_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_start,
    input logic          pd_test_req,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [DW-1:0] phy_data_in,
    input logic          phy_cap_addr,
    input logic          phy_cap_data,
    input logic          phy_write,
    input logic          phy_read,
    input logic          phy_pd_test
);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({phy_read, phy_write, phy_cap_data, phy_cap_addr}));

    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_start) |=> $stable(phy_data_in));

    assert_reset_write_no_wait_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(phy_write) && phy_data_in[0]) |-> done);

    assert_err_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    assert_pd_follow_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (phy_pd_test == $past(pd_test_req)));
endmodule

bind phyctl_hs_master phyctl_hs_master_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_start    (cmd_start),
    .pd_test_req  (pd_test_req),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .phy_data_in  (phy_data_in),
    .phy_cap_addr (phy_cap_addr),
    .phy_cap_data (phy_cap_data),
    .phy_write    (phy_write),
    .phy_read     (phy_read),
    .phy_pd_test  (phy_pd_test)
);

// File: tb/tb_phyctl_hs_master.sv
module tb_phyctl_hs_master;
    localparam int DW   = 16;
    localparam int GAP  = 8;
    localparam int MAXP = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_start = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [DW-1:0] cmd_operand = '0;
    logic          pd_test_req = 1'b0;
    logic          busy, done, err;
    logic [DW-1:0] rd_data, phy_data_in, phy_data_out;
    logic          phy_cap_addr, phy_cap_data, phy_write, phy_read, phy_pd_test, phy_ack;

    always #2.5 clk = ~clk;

    phyctl_hs_master #(.DW(DW), .POLL_GAP(GAP), .MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_operand(cmd_operand), .pd_test_req(pd_test_req), .busy(busy),
        .done(done), .err(err), .rd_data(rd_data), .phy_data_in(phy_data_in),
        .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
        .phy_write(phy_write), .phy_read(phy_read), .phy_pd_test(phy_pd_test),
        .phy_ack(phy_ack), .phy_data_out(phy_data_out)
    );

    // Behavioural PHY: mode 0 acks after 3 cycles, 1 never acks, 2 ack held high
    int            phy_mode = 0;
    logic [DW-1:0] rd_value = 16'hA5C3;
    logic [2:0]    dly;
    logic [3:0]    stb;
    logic          req;
    assign stb = {phy_read, phy_write, phy_cap_data, phy_cap_addr};
    assign req = (stb != 4'b0) && !(phy_write && phy_data_in[0]);
    always @(posedge clk) dly <= rst ? 3'b0 : {dly[1:0], req};
    assign phy_ack      = (phy_mode == 2) ? 1'b1 : (phy_mode == 1) ? 1'b0 : dly[2];
    assign phy_data_out = phy_read ? rd_value : 16'hDEAD;

    int n_chk = 0, n_fail = 0, cyc = 0, rise_cyc = 0, done_cyc = 0;
    logic [3:0] stb_prev = 4'b0;
    logic [3:0] expq[$];

    task automatic chk(input bit ok, input string req_s, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req_s, act, exp);
        end
    endtask

    // Reference model of the strobe sequence, compared on every clock
    always @(negedge clk) begin
        cyc++;
        if (!rst && stb != stb_prev) begin
            if (expq.size() == 0) chk(1'b0, "R2/R3/R5 unexpected strobe", 32'(stb), 32'(stb_prev));
            else begin
                chk(stb == expq[0], "R2/R3/R4/R5 strobe order", 32'(stb), 32'(expq[0]));
                void'(expq.pop_front());
            end
            if (stb_prev == 4'b0) rise_cyc = cyc;
            stb_prev = stb;
        end
        if (!rst && done) done_cyc = cyc;
    end

    task automatic start_cmd(input logic [1:0] op, input logic [DW-1:0] v);
        cmd_op = op; cmd_operand = v; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic launch(input logic [1:0] op, input logic [DW-1:0] v, input int n, input logic [15:0] evs);
        if (stb != 4'b0) expq.push_back(4'b0);
        for (int i = 0; i < n; i++) expq.push_back(evs[4*i +: 4]);
        start_cmd(op, v);
    endtask

    task automatic finish_op(input bit exp_err, input string tag);
        bit got = 0;
        logic e;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        e = err;
        chk(got, {tag, " done seen"}, 32'(got), 32'd1);
        chk(e == exp_err, {tag, " err"}, 32'(e), 32'(exp_err));
        @(negedge clk);
        chk(!done, "R8 done one cycle", 32'(done), 32'd0);
        chk(expq.size() == 0, {tag, " all phases seen"}, 32'(expq.size()), 32'd0);
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        chk(1'b0, "watchdog", 32'(cyc), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy, done, err, stb} == 7'b0 && phy_data_in == 0 && rd_data == 0,
            "R1 reset state", {busy, done, err, stb, phy_data_in}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R2 address capture
        launch(2'd0, 16'h2003, 2, 16'h0001);
        finish_op(1'b0, "R2");
        chk(phy_data_in == 16'h2003, "R2 data_in", 32'(phy_data_in), 32'h2003);

        // R3 normal write: cap_data then write
        launch(2'd1, 16'h1234, 4, 16'h0402);
        finish_op(1'b0, "R3");
        chk(phy_data_in == 16'h1234, "R3 data_in", 32'(phy_data_in), 32'h1234);

        // R5 read
        launch(2'd2, 16'h0BAD, 2, 16'h0008);
        finish_op(1'b0, "R5");
        chk(rd_data == 16'hA5C3, "R5 rd_data", 32'(rd_data), 32'hA5C3);
        chk(phy_data_in == 16'h1234, "R5 data_in kept", 32'(phy_data_in), 32'h1234);

        // R4 reset-bit write
        launch(2'd1, 16'h0001, 3, 16'h0402);
        finish_op(1'b0, "R4");
        chk(done_cyc == rise_cyc, "R4 done with write rise", 32'(done_cyc), 32'(rise_cyc));
        repeat (5) @(negedge clk);
        chk(phy_write && !busy, "R4 write held", {phy_write, busy}, 32'h2);

        // R6 rising-ack timeout
        phy_mode = 1;
        launch(2'd0, 16'h7F3F, 1, 16'h0001);
        finish_op(1'b1, "R6 rise timeout");
        chk(done_cyc - rise_cyc == 1 + (MAXP - 1) * GAP, "R6 timeout latency",
            32'(done_cyc - rise_cyc), 32'(1 + (MAXP - 1) * GAP));
        chk(phy_cap_addr, "R6 strobe left high", 32'(phy_cap_addr), 32'd1);

        // R6 err clears on next command
        phy_mode = 0;
        launch(2'd2, 16'h0, 2, 16'h0008);
        finish_op(1'b0, "R6 recovery");

        // R6 falling-ack timeout: write phase never runs
        phy_mode = 2;
        launch(2'd1, 16'h00F0, 2, 16'h0002);
        finish_op(1'b1, "R6 fall timeout");
        phy_mode = 0;
        repeat (4) @(negedge clk);

        // R7 start while busy ignored
        launch(2'd1, 16'h0F0E, 4, 16'h0402);
        repeat (3) @(negedge clk);
        start_cmd(2'd0, 16'hFFFF);
        chk(phy_data_in == 16'h0F0E, "R7 busy start data_in", 32'(phy_data_in), 32'h0F0E);
        finish_op(1'b0, "R7");
        repeat (10) @(negedge clk);
        chk(!busy && stb == 0, "R7 no extra command", {busy, stb}, 32'd0);

        // R7 reserved op ignored
        start_cmd(2'd3, 16'h5555);
        @(negedge clk);
        chk(!busy && phy_data_in == 16'h0F0E, "R7 reserved op", {busy, phy_data_in}, 32'h0F0E);

        // R9 power-down line independent of strobes
        pd_test_req = 1'b1;
        launch(2'd0, 16'h0042, 2, 16'h0001);
        chk(phy_pd_test, "R9 pd follows", 32'(phy_pd_test), 32'd1);
        finish_op(1'b0, "R9");
        chk(phy_pd_test, "R9 pd held", 32'(phy_pd_test), 32'd1);
        pd_test_req = 1'b0;
        @(negedge clk);
        chk(!phy_pd_test, "R9 pd cleared", 32'(phy_pd_test), 32'd0);
        chk(stb == 0 && !busy, "R10 idle strobes", 32'(stb), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule